// File: doc/BRIEF.md
# Accumulator and Link Operate Unit

This block executes the first group of operate microinstructions for a small 12-bit processor. It works on a 12-bit accumulator (AC) and a 1-bit link. Each bit of the instruction word enables one micro-operation independently, so a single word can request several at once. The enabled operations compose within one clock cycle in a fixed order: the two clears, then the two complements, then an increment of the 13-bit link:AC value, and last a single rotate, a double rotate or a swap of the two 6-bit halves of AC.

The surrounding core presents the instruction word, the current AC and link, and a one-cycle valid strobe. The unit registers the new AC and link on the edge where the strobe is high, so the result is ready on the next cycle. The unit has no stall path. If the strobe is high with a word outside this group, the current AC and link are registered unchanged. If the strobe is low, the outputs hold.

Top module: `opr_micro_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it is released, ac_o and link_o are zero.
- R2: With valid_i high, a word counts as a member of this group only when instr_i[11:9] is 3'b111 and instr_i[8] is 0. For any other word, the next ac_o and link_o equal ac_i and link_i.
- R3: With valid_i low, ac_o and link_o keep their values.
- R4: The clears come first. instr_i[7] sets AC to zero and instr_i[6] sets the link to zero.
- R5: The complements come after the clears. instr_i[5] inverts all AC bits and instr_i[4] inverts the link. A clear together with its complement gives an AC of all ones or a link of 1.
- R6: The increment comes after the complements. instr_i[0] adds one to the 13-bit value {link, AC}, so a carry out of AC toggles the link. Complement plus increment gives the two's complement, and clear plus increment gives 1.
- R7: instr_i[3] alone among the shift bits rotates the 13-bit ring {link, AC} right by one place. The link receives AC bit 0 (the LSB) and AC bit 11 receives the old link. This happens after the increment.
- R8: instr_i[2] alone among the shift bits rotates the ring left by one place. The link receives AC bit 11 and AC bit 0 receives the old link.
- R9: instr_i[1] set together with exactly one of the rotate bits rotates the ring twice in that direction.
- R10: instr_i[1] set with neither rotate bit swaps AC[11:6] with AC[5:0] after the clear, complement and increment steps. The link is left as those steps made it.

When instr_i[3] and instr_i[2] are both set, the result is not defined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 12 | Instruction word (bit 11 is the MSB) |
| ac_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link |
| ac_o | output | 12 | Registered next accumulator |
| link_o | output | 1 | Registered next link |

## Verification
The hardest case to reach is an increment carry that ripples into the link and is then moved by a later rotate or swap. That outcome needs an AC of all ones, or an AC that the complement step turns into all ones, combined with a rotate or swap bit. Directed words set up those corners, for example AC 0xFFF with increment plus double rotate, and complement plus increment plus swap. A long random phase follows. It biases AC toward 0x000 and 0xFFF and clears one rotate bit whenever both are drawn.

// File: rtl/opr_micro_unit.sv
module opr_micro_unit #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [11:0]   instr_i,
  input  logic [DW-1:0] ac_i,
  input  logic          link_i,
  output logic [DW-1:0] ac_o,
  output logic          link_o
);
  localparam int HALF = DW / 2;

  logic          hit;
  logic [DW-1:0] a_clr, a_cmp;
  logic          l_clr, l_cmp;
  logic [DW:0]   ring_inc, ring_out;

  assign hit   = valid_i && (instr_i[11:9] == 3'b111) && !instr_i[8];

  assign a_clr = instr_i[7] ? '0 : ac_i;
  assign l_clr = instr_i[6] ? 1'b0 : link_i;
  assign a_cmp = instr_i[5] ? ~a_clr : a_clr;
  assign l_cmp = l_clr ^ instr_i[4];
  assign ring_inc = {l_cmp, a_cmp} + {{DW{1'b0}}, instr_i[0]};

  always_comb begin
    case (instr_i[3:1])
      3'b100:  ring_out = {ring_inc[0], ring_inc[DW:1]};
      3'b101:  ring_out = {ring_inc[1:0], ring_inc[DW:2]};
      3'b010:  ring_out = {ring_inc[DW-1:0], ring_inc[DW]};
      3'b011:  ring_out = {ring_inc[DW-2:0], ring_inc[DW:DW-1]};
      3'b001:  ring_out = {ring_inc[DW], ring_inc[HALF-1:0], ring_inc[DW-1:HALF]};
      default: ring_out = ring_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       {link_o, ac_o} <= '0;
    else if (hit)     {link_o, ac_o} <= ring_out;
    else if (valid_i) {link_o, ac_o} <= {link_i, ac_i};
  end
endmodule

// File: rtl/opr_micro_unit_chk.sv
module opr_micro_unit_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic [11:0]   instr_i,
  input logic [DW-1:0] ac_i,
  input logic          link_i,
  input logic [DW-1:0] ac_o,
  input logic          link_o
);
  localparam int HALF = DW / 2;

  logic grp;
  assign grp = valid_i && instr_i[11:8] == 4'b1110;

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({link_o, ac_o}));

  // R2
  foreign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[11:8] != 4'b1110) |=> {link_o, ac_o} == $past({link_i, ac_i}));

  // R4
  clear_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[7] && !instr_i[5] && !instr_i[0] && instr_i[3:1] == 3'b000) |=> ac_o == '0);

  // R5
  set_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[7] && instr_i[5] && !instr_i[0] && instr_i[3:1] == 3'b000) |=> &ac_o);

  // R5
  set_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[6] && instr_i[4] && !instr_i[0] && instr_i[3:1] == 3'b000) |=> link_o);

  // R7
  rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[7:0] == 8'b0000_1000) |=>
      (ac_o == {$past(link_i), $past(ac_i[DW-1:1])}) && (link_o == $past(ac_i[0])));

  // R8
  rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[7:0] == 8'b0000_0100) |=>
      (ac_o == {$past(ac_i[DW-2:0]), $past(link_i)}) && (link_o == $past(ac_i[DW-1])));

  // R10
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && instr_i[7:0] == 8'b0000_0010) |=>
      (ac_o == {$past(ac_i[HALF-1:0]), $past(ac_i[DW-1:HALF])}) && (link_o == $past(link_i)));
endmodule

bind opr_micro_unit opr_micro_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
  .ac_i(ac_i), .link_i(link_i), .ac_o(ac_o), .link_o(link_o)
);

// File: tb/opr_micro_unit_tb.sv
module opr_micro_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_i = 0;
  logic [11:0] instr_i = 0;
  logic [11:0] ac_i = 0;
  logic        link_i = 0;
  logic [11:0] ac_o;
  logic        link_o;

  int total = 0;
  int bad = 0;
  int exp_ac = 0;
  int exp_l = 0;
  string exp_tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr_micro_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .ac_i(ac_i), .link_i(link_i), .ac_o(ac_o), .link_o(link_o)
  );

  function automatic string tag_of(input logic v, input logic [11:0] w);
    if (!v) return "R3";
    if (w[11:8] != 4'b1110) return "R2";
    if (w[1] && !w[3] && !w[2]) return "R10";
    if (w[1]) return "R9";
    if (w[3]) return "R7";
    if (w[2]) return "R8";
    if (w[0]) return "R6";
    if (w[5] || w[4]) return "R5";
    return "R4";
  endfunction

  always @(posedge clk) begin
    int a, l, v;
    if (!rst_n) begin
      exp_ac = 0; exp_l = 0; exp_tag = "R1";
    end else if (valid_i) begin
      exp_tag = tag_of(valid_i, instr_i);
      a = ac_i; l = link_i;
      if (instr_i[11:8] == 4'b1110) begin
        if (instr_i[7]) a = 0;
        if (instr_i[6]) l = 0;
        if (instr_i[5]) a = 4095 - a;
        if (instr_i[4]) l = 1 - l;
        if (instr_i[0]) begin
          v = (l * 4096 + a + 1) % 8192;
          l = v / 4096; a = v % 4096;
        end
        if (instr_i[3] || instr_i[2]) begin
          for (int k = 0; k < (instr_i[1] ? 2 : 1); k++) begin
            v = l * 4096 + a;
            if (instr_i[3]) v = (v % 2) * 4096 + v / 2;
            else            v = (v * 2) % 8192 + v / 4096;
            l = v / 4096; a = v % 4096;
          end
        end else if (instr_i[1]) begin
          a = (a % 64) * 64 + a / 64;
        end
      end
      exp_ac = a; exp_l = l;
    end else begin
      exp_tag = "R3";
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (ac_o !== exp_ac[11:0] || link_o !== exp_l[0]) begin
        bad++;
        $display("FAIL %s: ac=%03h link=%0d expected ac=%03h link=%0d",
                 exp_tag, ac_o, link_o, exp_ac[11:0], exp_l[0]);
      end
    end
  end

  task automatic op(input logic [11:0] w, input logic [11:0] a, input logic l);
    @(negedge clk);
    valid_i = 1; instr_i = w; ac_i = a; link_i = l;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0; instr_i = $urandom; ac_i = $urandom; link_i = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state checked on every cycle above, R3 hold with junk inputs
    idle(); idle();
    // R4 / R5 clears and complements
    op(12'o7200, 12'h5A5, 1);  op(12'o7100, 12'h5A5, 1);
    op(12'o7240, 12'h123, 0);  op(12'o7120, 12'h123, 0);
    op(12'o7040, 12'h0F0, 1);  op(12'o7020, 12'h0F0, 1);
    // R6 increment corners
    op(12'o7041, 12'h005, 0);  op(12'o7201, 12'hABC, 1);
    op(12'o7001, 12'hFFF, 0);  op(12'o7001, 12'hFFF, 1);
    op(12'o7041, 12'h000, 0);
    // R7 R8 R9 rotates, including carry feeding the ring
    op(12'o7010, 12'h801, 0);  op(12'o7004, 12'h801, 1);
    op(12'o7012, 12'h003, 0);  op(12'o7006, 12'hC00, 1);
    op(12'o7013, 12'hFFF, 0);  op(12'o7005, 12'hFFF, 0);
    // R10 swap, alone and after complement plus increment
    op(12'o7002, 12'hABC, 1);  op(12'o7043, 12'h001, 0);
    op(12'o7003, 12'hFFF, 0);
    // R2 words outside the group
    op(12'o7401, 12'h3C3, 1);  op(12'o5123, 12'h111, 0);
    op(12'o6001, 12'h222, 1);
    idle();
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] w, a;
      w = $urandom;
      if ($urandom % 8 != 0) w[11:8] = 4'b1110;
      if (w[3]) w[2] = 0;
      case ($urandom % 4)
        0: a = 12'h000;
        1: a = 12'hFFF;
        default: a = $urandom;
      endcase
      if ($urandom % 6 == 0) idle();
      else op(w, a, $urandom);
    end
    idle();
    @(negedge clk);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule